// File: doc/BRIEF.md
# BCD Real-Time Calendar Core

This block keeps wall-clock time and calendar date in packed BCD. It runs on the system clock and advances only on cycles where a slow-clock enable (`rtc_ce`) is high. Two cascaded down-counters turn that enable into a one-second tick. The tick steps seconds, minutes and hours in 24-hour form, then the weekday, the day of month, the month and a two-digit year. Month lengths and leap Februaries are handled.

Software reaches the block through a plain register port. The port has one write strobe, a two-bit word address, write data and a combinational read bus. There is no stream traffic, so there is no valid/ready handshake and the port cannot apply back-pressure. A write takes effect on the clock edge where `reg_wr` is high, and a read returns data in the same cycle. To load time, date or the prescaler, software first sets the init request bit. It then waits for the init-ready flag, which follows two slow-clock pulses later, and writes the words. Finally it clears the request. While the request is set, the calendar and the prescaler are frozen.

The time and date words read back from shadow copies, which capture the live calendar on every slow-clock pulse. A sync flag is cleared by software. Hardware sets it again once the shadows are known to be coherent.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time word reads 0x00000000, the date word reads 0x00002101 (year 00, weekday 1, month 01, day 01), the control word reads 0, and the prescaler word reads async 127 / sync 255 (0x007F00FF). Word addresses: 0 = time, 1 = date, 2 = control, 3 = prescaler.
- R2: The prescaler word holds the sync divider S in bits 14:0 and the async divider A in bits 22:16. Once init is released, a second tick occurs on every (A+1)×(S+1)-th slow-clock pulse, counting from the first pulse after release.
- R3: The time word holds BCD seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16. On a tick, seconds wrap 59→00 and carry into minutes, minutes wrap 59→00 and carry into hours, and hours wrap 23→00 and carry into the day.
- R4: The date word holds BCD day in bits 5:0, month in bits 12:8, weekday in bits 15:13 and year in bits 23:16. The weekday uses 1 = Monday to 7 = Sunday and advances by one on each day carry, with 7 followed by 1.
- R5: The day of month wraps to 01 after day 31, 30 or 28/29, depending on the month. February has 29 days when the two-digit year is divisible by 4, and 00 counts as divisible.
- R6: On a month carry, month 12 goes to 01 and the year increments, with 99 followed by 00.
- R7: Control bit 0 (init request) is read/write, and control bit 1 (init ready) is read-only. Init ready rises on the second slow-clock pulse after the request is set. It drops on the edge that clears the request. While the request is set, the calendar does not change except through the load writes.
- R8: Writes to the time, date or prescaler word are ignored unless init ready is 1.
- R9: Control bit 2 is the sync flag. Writing the control word with bit 2 = 0, or with the init request set, clears it, and writing it with bit 2 = 1 leaves it unchanged. With the request clear, hardware sets it on the second slow-clock pulse after it was cleared. It is never 1 while init ready is 1.
- R10: Control bit 3 reads 1 exactly when the live year field is nonzero. Control bit 6 (hour format) always reads 0, meaning 24-hour mode.
- R11: Reads of the time and date words return the calendar value captured on the most recent slow-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_ce | input | 1 | Slow-clock enable, one pulse per slow-clock period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 time, 1 date, 2 control, 3 prescaler |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |

## Verification
The bench targets the carry chain at its extremes:
- The last second of the last day of year 99, where a missed carry would leave 59 in a field or keep year 99.
- The last day of February in leap years and in common years, including year 00, where a wrong leap rule lands on day 29 or 30 instead of March 1.
- The last day of a 30-day month, where a design using a single month length would skip to day 31.

It counts slow-clock pulses to check that the divider product holds exactly for several divider pairs, where an off-by-one divider would drift within a few seconds. It also checks the init and sync handshakes pulse by pulse: early acknowledgement, a write accepted outside init mode, or a sync flag set by writing 1 would each show up at the ports.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam logic [1:0] ADDR_TIME  = 2'd0;
  localparam logic [1:0] ADDR_DATE  = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_PRESC = 2'd3;

  localparam int CB_INIT  = 0;
  localparam int CB_READY = 1;
  localparam int CB_SYNC  = 2;
  localparam int CB_SET   = 3;

  typedef struct packed {
    logic [7:0] yr;
    logic [4:0] mo;
    logic [2:0] wd;
    logic [5:0] dt;
    logic [5:0] hr;
    logic [6:0] mn;
    logic [6:0] sc;
  } cal_t;

  localparam cal_t CAL_RESET = '{yr: 8'h00, mo: 5'h01, wd: 3'd1, dt: 6'h01,
                                 hr: 6'h00, mn: 7'h00, sc: 7'h00};

  // Step a BCD value; returns 'first' after 'last'.
  function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                          input logic [7:0] last,
                                          input logic [7:0] first);
    if (v == last) return first;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
    logic [6:0] y;
    y = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mo)
      8'h02:                      return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [31:0] time_word(input cal_t c);
    return {10'b0, c.hr, 1'b0, c.mn, 1'b0, c.sc};
  endfunction

  function automatic logic [31:0] date_word(input cal_t c);
    return {8'b0, c.yr, c.wd, c.mo, 2'b0, c.dt};
  endfunction
endpackage

// File: rtl/rtc_init_ctrl.sv
module rtc_init_ctrl #(
  parameter int SYNC_CE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic wr_ctrl,
  input  logic init_in,
  input  logic sync_in,
  output logic init_req,
  output logic init_rdy,
  output logic sync_flag
);
  localparam int CW = $clog2(SYNC_CE + 1);
  localparam logic [CW-1:0] LAST = CW'(SYNC_CE - 1);

  logic [CW-1:0] icnt, scnt;
  logic          drop_init, drop_sync;

  assign drop_init = !init_req || (wr_ctrl && !init_in);
  assign drop_sync = init_req || (wr_ctrl && (init_in || !sync_in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req  <= 1'b0;
      init_rdy  <= 1'b0;
      sync_flag <= 1'b0;
      icnt      <= '0;
      scnt      <= '0;
    end else begin
      if (wr_ctrl) init_req <= init_in;

      if (drop_init) begin
        init_rdy <= 1'b0;
        icnt     <= '0;
      end else if (!init_rdy && ce) begin
        if (icnt == LAST) init_rdy <= 1'b1;
        else              icnt     <= icnt + 1'b1;
      end

      if (drop_sync) begin
        sync_flag <= 1'b0;
        scnt      <= '0;
      end else if (!sync_flag && ce) begin
        if (scnt == LAST) sync_flag <= 1'b1;
        else              scnt      <= scnt + 1'b1;
      end
    end
  end

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    init_rdy |-> init_req); // R7
  AST_READY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_rdy) |-> ($past(ce) && $past(init_req))); // R7
  AST_SYNC_LOW_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_rdy |-> !sync_flag); // R9
  AST_SYNC_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_flag) |-> ($past(ce) && !$past(init_req))); // R9
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int AW    = 7,
  parameter int SW    = 15,
  parameter int A_RST = 127,
  parameter int S_RST = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          hold,
  input  logic          ld,
  input  logic [AW-1:0] a_in,
  input  logic [SW-1:0] s_in,
  output logic [AW-1:0] a_div,
  output logic [SW-1:0] s_div,
  output logic          tick
);
  logic [AW-1:0] a_cnt;
  logic [SW-1:0] s_cnt;

  assign tick = ce && !hold && (a_cnt == '0) && (s_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_div <= AW'(A_RST);
      s_div <= SW'(S_RST);
      a_cnt <= AW'(A_RST);
      s_cnt <= SW'(S_RST);
    end else begin
      if (ld) begin
        a_div <= a_in;
        s_div <= s_in;
      end
      if (hold) begin
        a_cnt <= a_div;
        s_cnt <= s_div;
      end else if (ce) begin
        if (a_cnt == '0) begin
          a_cnt <= a_div;
          s_cnt <= (s_cnt == '0) ? s_div : s_cnt - 1'b1;
        end else begin
          a_cnt <= a_cnt - 1'b1;
        end
      end
    end
  end

  AST_RELOAD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (a_cnt == a_div && s_cnt == s_div)); // R2
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        ld_time,
  input  logic        ld_date,
  input  logic [31:0] wdata,
  output cal_t        cal
);
  cal_t       nxt;
  logic [7:0] sc_n, mn_n, hr_n, dt_n, mo_n, yr_n;
  logic       c_s, c_m, c_h, c_d, c_mo;

  always_comb begin
    c_s  = ({1'b0, cal.sc} == 8'h59);
    c_m  = c_s && ({1'b0, cal.mn} == 8'h59);
    c_h  = c_m && ({2'b0, cal.hr} == 8'h23);
    c_d  = c_h && ({2'b0, cal.dt} == month_len({3'b0, cal.mo}, cal.yr));
    c_mo = c_d && ({3'b0, cal.mo} == 8'h12);
    sc_n = bcd_next({1'b0, cal.sc}, 8'h59, 8'h00);
    mn_n = bcd_next({1'b0, cal.mn}, 8'h59, 8'h00);
    hr_n = bcd_next({2'b0, cal.hr}, 8'h23, 8'h00);
    dt_n = bcd_next({2'b0, cal.dt}, month_len({3'b0, cal.mo}, cal.yr), 8'h01);
    mo_n = bcd_next({3'b0, cal.mo}, 8'h12, 8'h01);
    yr_n = bcd_next(cal.yr, 8'h99, 8'h00);
    nxt    = cal;
    nxt.sc = sc_n[6:0];
    if (c_s)  nxt.mn = mn_n[6:0];
    if (c_m)  nxt.hr = hr_n[5:0];
    if (c_h) begin
      nxt.wd = (cal.wd == 3'd7) ? 3'd1 : cal.wd + 3'd1;
      nxt.dt = dt_n[5:0];
    end
    if (c_d)  nxt.mo = mo_n[4:0];
    if (c_mo) nxt.yr = yr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal <= CAL_RESET;
    end else if (ld_time) begin
      cal.sc <= wdata[6:0];
      cal.mn <= wdata[14:8];
      cal.hr <= wdata[21:16];
    end else if (ld_date) begin
      cal.dt <= wdata[5:0];
      cal.mo <= wdata[12:8];
      cal.wd <= wdata[15:13];
      cal.yr <= wdata[23:16];
    end else if (tick) begin
      cal <= nxt;
    end
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cal.sc == 7'h59) |=> (cal.sc == 7'h00)); // R3
  AST_DAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cal.sc == 7'h59 && cal.mn == 7'h59 && cal.hr == 6'h23)
      |=> (cal.hr == 6'h00 && cal.wd != $past(cal.wd))); // R4
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_cal_pkg::*;
#(
  parameter int ASYNC_W   = 7,
  parameter int SYNC_W    = 15,
  parameter int ASYNC_RST = 127,
  parameter int SYNC_RST  = 255,
  parameter int SYNC_CE   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rtc_ce,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int A_LSB = 16;

  cal_t               cal;
  logic               init_req, init_rdy, sync_flag, tick;
  logic               ld_time, ld_date, ld_presc, wr_ctrl;
  logic [ASYNC_W-1:0] a_div;
  logic [SYNC_W-1:0]  s_div;
  logic [31:0]        time_sh, date_sh, presc_word, ctrl_word;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign ld_time  = reg_wr && (reg_addr == ADDR_TIME)  && init_rdy;
  assign ld_date  = reg_wr && (reg_addr == ADDR_DATE)  && init_rdy;
  assign ld_presc = reg_wr && (reg_addr == ADDR_PRESC) && init_rdy;

  rtc_init_ctrl #(.SYNC_CE(SYNC_CE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(rtc_ce), .wr_ctrl(wr_ctrl),
    .init_in(reg_wdata[CB_INIT]), .sync_in(reg_wdata[CB_SYNC]),
    .init_req(init_req), .init_rdy(init_rdy), .sync_flag(sync_flag));

  rtc_prescaler #(.AW(ASYNC_W), .SW(SYNC_W), .A_RST(ASYNC_RST), .S_RST(SYNC_RST)) u_presc (
    .clk(clk), .rst_n(rst_n), .ce(rtc_ce), .hold(init_req), .ld(ld_presc),
    .a_in(reg_wdata[A_LSB +: ASYNC_W]), .s_in(reg_wdata[SYNC_W-1:0]),
    .a_div(a_div), .s_div(s_div), .tick(tick));

  rtc_cal_counter u_cal (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_time(ld_time),
    .ld_date(ld_date), .wdata(reg_wdata), .cal(cal));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_sh <= time_word(CAL_RESET);
      date_sh <= date_word(CAL_RESET);
    end else if (rtc_ce) begin
      time_sh <= time_word(cal);
      date_sh <= date_word(cal);
    end
  end

  always_comb begin
    presc_word = '0;
    presc_word[SYNC_W-1:0]       = s_div;
    presc_word[A_LSB +: ASYNC_W] = a_div;
    ctrl_word = '0;
    ctrl_word[CB_INIT]  = init_req;
    ctrl_word[CB_READY] = init_rdy;
    ctrl_word[CB_SYNC]  = sync_flag;
    ctrl_word[CB_SET]   = (cal.yr != 8'h00);
    case (reg_addr)
      ADDR_TIME: reg_rdata = time_sh;
      ADDR_DATE: reg_rdata = date_sh;
      ADDR_CTRL: reg_rdata = ctrl_word;
      default:   reg_rdata = presc_word;
    endcase
  end

  AST_PRESC_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_PRESC && !init_rdy) |=> $stable(presc_word)); // R8
  AST_FROZEN_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (init_rdy && !ld_time && !ld_date) |=> $stable(cal)); // R7
endmodule

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rtc_ce = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;
  int ms, mm, mh, mw, md, mmo, my;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_core dut_i (
    .clk(clk), .rst_n(rst_n), .rtc_ce(rtc_ce), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic int bcd(input int x);
    return ((x / 10) << 4) | (x % 10);
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] exp_time();
    return 32'((bcd(mh) << 16) | (bcd(mm) << 8) | bcd(ms));
  endfunction

  function automatic logic [31:0] exp_date();
    return 32'((bcd(my) << 16) | (mw << 13) | (bcd(mmo) << 8) | bcd(md));
  endfunction

  task automatic step_sec();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mw = (mw == 7) ? 1 : mw + 1;
          md++;
          if (md > dim(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      rtc_ce = 1'b1;
      @(negedge clk);
      rtc_ce = 1'b0;
    end
  endtask

  task automatic load(input int h, input int m, input int s, input int w, input int d,
                      input int mo, input int y, input int a, input int sv);
    logic [31:0] r;
    wr(2'd2, 32'h1);
    rd(2'd2, r); chk("R7 ready low at request", 32'(r[1]), 32'd0);
    pulses(1);
    rd(2'd2, r); chk("R7 ready low after one pulse", 32'(r[1]), 32'd0);
    pulses(1);
    rd(2'd2, r); chk("R7 ready after two pulses", 32'(r[1]), 32'd1);
    chk("R9 sync low in init", 32'(r[2]), 32'd0);
    mh = h; mm = m; ms = s; mw = w; md = d; mmo = mo; my = y;
    wr(2'd0, exp_time());
    wr(2'd1, exp_date());
    wr(2'd3, 32'((a << 16) | sv));
    pulses(3);
    rd(2'd0, r); chk("R7 R11 frozen time", r, exp_time());
    rd(2'd1, r); chk("R7 R11 frozen date", r, exp_date());
    rd(2'd3, r); chk("R2 prescaler word", r, 32'((a << 16) | sv));
    rd(2'd2, r); chk("R10 year-set flag", 32'(r[3]), 32'(y != 0));
    wr(2'd2, 32'h0);
  endtask

  task automatic run(input int p, input int dv, input string req);
    logic [31:0] r;
    pulses(p);
    for (int i = 0; i < (p - 1) / dv; i++) step_sec();
    rd(2'd0, r); chk({req, " time"}, r, exp_time());
    rd(2'd1, r); chk({req, " date"}, r, exp_date());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, r); chk("R1 reset time", r, 32'h0);
    rd(2'd1, r); chk("R1 reset date", r, 32'h00002101);
    rd(2'd2, r); chk("R1 R10 reset control", r, 32'h0);
    rd(2'd3, r); chk("R1 reset prescaler", r, 32'h007F00FF);

    wr(2'd3, 32'h00010001);
    rd(2'd3, r); chk("R8 prescaler write ignored", r, 32'h007F00FF);
    wr(2'd0, 32'h00123456);
    wr(2'd1, 32'h00994512);
    pulses(1);
    rd(2'd0, r); chk("R8 time write ignored", r, 32'h0);
    rd(2'd1, r); chk("R8 date write ignored", r, 32'h00002101);
    pulses(1);
    rd(2'd2, r); chk("R9 sync set after reset", 32'(r[2]), 32'd1);
    chk("R10 format bit zero", 32'(r[6]), 32'd0);

    // Sync flag handshake with a slow divider so no tick interferes
    load(10, 0, 0, 1, 1, 1, 0, 127, 255);
    pulses(1);
    rd(2'd2, r); chk("R9 sync low one pulse after exit", 32'(r[2]), 32'd0);
    chk("R7 ready dropped on exit", 32'(r[1]), 32'd0);
    pulses(1);
    rd(2'd2, r); chk("R9 sync set two pulses after exit", 32'(r[2]), 32'd1);
    wr(2'd2, 32'h4);
    rd(2'd2, r); chk("R9 writing one keeps flag", 32'(r[2]), 32'd1);
    wr(2'd2, 32'h0);
    rd(2'd2, r); chk("R9 cleared by writing zero", 32'(r[2]), 32'd0);
    pulses(2);
    rd(2'd2, r); chk("R9 resynced", 32'(r[2]), 32'd1);

    // Directed carries, divider product 4
    load(23, 59, 59, 7, 31, 12, 99, 1, 1);
    run(5, 4, "R3 R4 R6 end of year 99");
    rd(2'd2, r); chk("R10 year-set clears at 00", 32'(r[3]), 32'd0);
    load(23, 59, 59, 3, 28, 2, 24, 1, 1);
    run(5, 4, "R5 leap Feb 28");
    load(23, 59, 59, 4, 28, 2, 23, 1, 1);
    run(5, 4, "R5 common Feb 28");
    load(23, 59, 59, 6, 29, 2, 0, 1, 1);
    run(5, 4, "R5 year 00 Feb 29");
    load(23, 59, 59, 5, 30, 4, 10, 1, 1);
    run(5, 4, "R5 Apr 30");
    load(12, 59, 59, 2, 15, 6, 33, 1, 1);
    run(5, 4, "R3 hour carry");
    load(8, 0, 57, 1, 9, 9, 1, 2, 1);
    run(19, 6, "R2 divider 3x2");
    load(8, 0, 57, 1, 9, 9, 1, 2, 1);
    run(18, 6, "R2 divider edge");

    for (int i = 0; i < 12; i++) begin
      int a, sv, dv, y, mo;
      a  = $urandom % 4;
      sv = $urandom % 4;
      dv = (a + 1) * (sv + 1);
      y  = $urandom % 100;
      mo = 1 + $urandom % 12;
      load($urandom % 24, $urandom % 60, 50 + $urandom % 10, 1 + $urandom % 7,
           1 + $urandom % dim(mo, y), mo, y, a, sv);
      run(1 + $urandom % (dv * 8), dv, "R2 R3 R4 random");
    end

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule